// File: doc/BRIEF.md
# Hashed Page Table Walker

This block translates a virtual address through a hashed page table in memory when no block translation matched. It picks one of sixteen segment registers with the top address bits. It refuses direct-store segments and instruction fetches from no-execute segments at once. Otherwise it forms a protection key from the privilege level and the segment's two key bits, then hashes the segment's virtual segment ID with the page index to locate a group of eight page-table entries.

The walker reads the entries of the primary group one at a time over a simple memory port with a valid/ready handshake. If none of them matches, it searches a secondary group whose hash is the complement of the primary one. On a match it decodes the entry's two protection bits under the key, sets the referenced bit in the entry's second word, sets the changed bit on a permitted store, and writes that word back. It then reports the real page number and the read/write permissions, or a fault code. A caller pulses `start` and waits for the one-cycle `done`. The results hold until the next start.

Top module: `hpt_walker`

## Requirements
- R1: The segment register is the one indexed by `vaddr[31:28]`. The key is 1 when (segment bit 29 and `user_mode`) or (segment bit 30 and not `user_mode`), and 0 otherwise.
- R2: A segment with bit 31 set, or a fetch (`is_fetch`) from a segment with bit 28 set, ends with fault code 0x10000000 (ORed with 0x02000000 when `is_write`) and makes no memory access.
- R3: The primary hash is ((VSID XOR page index) AND 0x7FFFF) << 6, where VSID is segment bits 23:0 and the page index is `vaddr[27:12]`. The group address is (`sdr1` AND 0xFFFF0000) OR (hash AND mask), where the mask is (`sdr1[8:0]` << 16) OR 0xFFC0. Entry i sits at group + 8*i, with word0 first and word1 at +4.
- R4: An entry matches only when word0 bit 31 is 1, word0 bit 6 equals the current search pass (0 primary, 1 secondary), and word0 with bits 31 and 6 cleared equals (VSID << 7) OR (page index >> 10).
- R5: After eight primary misses the walker searches the secondary group, whose hash is (NOT primary hash) AND 0x01FFFFC0, using the same address formula.
- R6: When neither group matches, the result is fault code 0x40000000, ORed with 0x02000000 for a store.
- R7: With key 0, the protection bits (word1 bits 1:0) always allow reads and allow writes unless they equal 3.
- R8: With key 1, protection 0 allows nothing, 1 and 3 allow read only, and 2 allows read and write.
- R9: When the access is not allowed, the result is fault code 0x08000000, ORed with 0x02000000 for a store, with `hit` low. A successful translation reports fault code 0 with `hit` high.
- R10: After any match, word1 is written back to entry address + 4 with bit 8 (referenced) set. Bit 7 (changed) is also set on a permitted store.
- R11: The reported write permission is cleared when word1 bit 7 was clear and the access is not a permitted store. `rpn` is word1 bits 31:12.
- R12: Only one memory request is outstanding, and it holds its address and direction until `mem_ready`. `busy` is high from the cycle after `start` through the `done` cycle, and `done` lasts one cycle.
- R13: The search stops at the first matching entry in a group, so that entry's page number is returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk (taken when idle) |
| vaddr | input | 32 | Virtual address |
| is_write | input | 1 | Access is a store |
| is_fetch | input | 1 | Access is an instruction fetch |
| user_mode | input | 1 | Access made in user mode |
| sdr1 | input | 32 | Table base (bits 31:16) and size mask (bits 8:0) |
| seg_regs | input | 512 | Sixteen 32-bit segment registers, register i at bits 32*i+31:32*i |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Request byte address |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Request accepted; read data valid |
| mem_rdata | input | 32 | Read data |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| hit | output | 1 | Translation succeeded |
| rpn | output | 20 | Real page number |
| perm_r | output | 1 | Read permitted |
| perm_w | output | 1 | Write permitted |
| fault_code | output | 32 | Fault status, 0 on success |

## Verification
In a single walk, the cycle that reads a matching word1 both grants or denies the access and decides the changed-bit update. So a store whose protection check fails must still write back a referenced-only word1, and a read must still write back while it loses write permission. The bench sets up matching entries whose protection bits deny a store, and others that allow it with the changed bit clear. For each case it records the data that reaches the write-back and checks it against the reported fault and permissions from the same walk.

// File: rtl/hpt_pkg.sv
package hpt_pkg;

    localparam int WORD_W = 32;

    localparam logic [31:0] FLT_NOPTE  = 32'h4000_0000;
    localparam logic [31:0] FLT_PROT   = 32'h0800_0000;
    localparam logic [31:0] FLT_NOEXEC = 32'h1000_0000;
    localparam logic [31:0] FLT_STORE  = 32'h0200_0000;
    localparam logic [31:0] PTE_REF    = 32'h0000_0100;
    localparam logic [31:0] PTE_CHG    = 32'h0000_0080;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD0,
        ST_RD1,
        ST_WB,
        ST_DONE
    } walk_st_e;

    typedef struct packed {
        logic [23:0] vsid;
        logic [15:0] pgidx;
        logic        key;
        logic        dstore;
        logic        noexec;
    } seg_info_t;

    typedef struct packed {
        logic r;
        logic w;
    } perm_t;

    function automatic logic [31:0] primary_hash(input logic [23:0] vsid,
                                                 input logic [15:0] pgidx);
        logic [31:0] x;
        x = {8'h00, vsid} ^ {16'h0000, pgidx};
        return (x & 32'h0007_FFFF) << 6;
    endfunction

    function automatic logic [31:0] group_addr(input logic [15:0] tbase,
                                               input logic [8:0]  tmask,
                                               input logic [31:0] hash);
        logic [31:0] m;
        m = ({23'd0, tmask} << 16) | 32'h0000_FFC0;
        return {tbase, 16'h0000} | (hash & m);
    endfunction

    function automatic perm_t pp_decode(input logic key, input logic [1:0] pp);
        perm_t p;
        if (!key) begin
            p.r = 1'b1;
            p.w = (pp != 2'd3);
        end else begin
            p.r = (pp != 2'd0);
            p.w = (pp == 2'd2);
        end
        return p;
    endfunction

endpackage

// File: rtl/hpt_seg_sel.sv
module hpt_seg_sel
    import hpt_pkg::*;
#(
    parameter int N_SEG = 16
) (
    input  logic [N_SEG*WORD_W-1:0] seg_regs,
    input  logic [31:0]             vaddr,
    input  logic                    user_mode,
    output seg_info_t               info
);
    localparam int SEL_W = $clog2(N_SEG);

    logic [WORD_W-1:0] segs [N_SEG];

    for (genvar g = 0; g < N_SEG; g++) begin : g_unpack
        assign segs[g] = seg_regs[g*WORD_W +: WORD_W];
    end

    logic [SEL_W-1:0]  sel;
    logic [WORD_W-1:0] sr;

    assign sel = vaddr[31 -: SEL_W];
    assign sr  = segs[sel];

    always_comb begin
        info.vsid   = sr[23:0];
        info.pgidx  = vaddr[27:12];
        info.key    = (sr[29] & user_mode) | (sr[30] & ~user_mode);
        info.dstore = sr[31];
        info.noexec = sr[28];
    end

    logic unused_seg;
    assign unused_seg = ^{sr[27:24], vaddr[11:0]};

endmodule

// File: rtl/hpt_pte_chk.sv
module hpt_pte_chk
    import hpt_pkg::*;
(
    input  logic [31:0] w0,
    input  logic [31:0] w1,
    input  logic [23:0] vsid,
    input  logic [15:0] pgidx,
    input  logic        pass_h,
    input  logic        key,
    input  logic        is_write,
    output logic        match,
    output logic        allowed,
    output perm_t       perm,
    output logic [31:0] wb_data
);
    logic [31:0] ptem;
    logic [31:0] w0_cmp;
    perm_t       base;
    logic        set_chg;

    assign ptem   = {1'b0, vsid, 1'b0, pgidx[15:10]};
    assign w0_cmp = {1'b0, w0[30:7], 1'b0, w0[5:0]};

    always_comb begin
        match   = w0[31] && (w0[6] == pass_h) && (w0_cmp == ptem);
        base    = pp_decode(key, w1[1:0]);
        allowed = is_write ? base.w : base.r;
        set_chg = is_write && allowed;
        wb_data = w1 | PTE_REF | (set_chg ? PTE_CHG : 32'h0);
        perm.r  = base.r;
        perm.w  = base.w && (w1[7] || set_chg);
    end

endmodule

// File: rtl/hpt_walker.sv
module hpt_walker
    import hpt_pkg::*;
#(
    parameter int N_SEG = 16,
    parameter int N_ENT = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic [31:0]             vaddr,
    input  logic                    is_write,
    input  logic                    is_fetch,
    input  logic                    user_mode,
    input  logic [31:0]             sdr1,
    input  logic [N_SEG*WORD_W-1:0] seg_regs,
    output logic                    mem_req,
    output logic                    mem_we,
    output logic [31:0]             mem_addr,
    output logic [31:0]             mem_wdata,
    input  logic                    mem_ready,
    input  logic [31:0]             mem_rdata,
    output logic                    busy,
    output logic                    done,
    output logic                    hit,
    output logic [19:0]             rpn,
    output logic                    perm_r,
    output logic                    perm_w,
    output logic [31:0]             fault_code
);
    localparam int IDX_W = $clog2(N_ENT);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_ENT - 1);

    walk_st_e    st_q;
    seg_info_t   seg_now, info_q;
    logic [15:0] tbase_q;
    logic [8:0]  tmask_q;
    logic        write_q;
    logic        pass_q;
    logic [IDX_W-1:0] idx_q;
    logic [31:0] w0_q, wb_q;
    logic        hit_q, pr_q, pw_q;
    logic [19:0] rpn_q;
    logic [31:0] fault_q;

    hpt_seg_sel #(.N_SEG(N_SEG)) u_seg (
        .seg_regs (seg_regs),
        .vaddr    (vaddr),
        .user_mode(user_mode),
        .info     (seg_now)
    );

    logic        c_match, c_allowed;
    perm_t       c_perm;
    logic [31:0] c_wb;

    hpt_pte_chk u_chk (
        .w0      (w0_q),
        .w1      (mem_rdata),
        .vsid    (info_q.vsid),
        .pgidx   (info_q.pgidx),
        .pass_h  (pass_q),
        .key     (info_q.key),
        .is_write(write_q),
        .match   (c_match),
        .allowed (c_allowed),
        .perm    (c_perm),
        .wb_data (c_wb)
    );

    logic [31:0] hash_p, hash_s, grp, ent_addr;
    logic [31:0] store_bit;

    always_comb begin
        hash_p    = primary_hash(info_q.vsid, info_q.pgidx);
        hash_s    = ~hash_p & 32'h01FF_FFC0;
        grp       = group_addr(tbase_q, tmask_q, pass_q ? hash_s : hash_p);
        ent_addr  = grp + (32'(idx_q) << 3);
        store_bit = write_q ? FLT_STORE : 32'h0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            info_q  <= '0;
            tbase_q <= '0;
            tmask_q <= '0;
            write_q <= 1'b0;
            pass_q  <= 1'b0;
            idx_q   <= '0;
            w0_q    <= '0;
            wb_q    <= '0;
            hit_q   <= 1'b0;
            pr_q    <= 1'b0;
            pw_q    <= 1'b0;
            rpn_q   <= '0;
            fault_q <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        info_q  <= seg_now;
                        tbase_q <= sdr1[31:16];
                        tmask_q <= sdr1[8:0];
                        write_q <= is_write;
                        pass_q  <= 1'b0;
                        idx_q   <= '0;
                        hit_q   <= 1'b0;
                        pr_q    <= 1'b0;
                        pw_q    <= 1'b0;
                        rpn_q   <= '0;
                        if (seg_now.dstore || (is_fetch && seg_now.noexec)) begin
                            fault_q <= FLT_NOEXEC | (is_write ? FLT_STORE : 32'h0);
                            st_q    <= ST_DONE;
                        end else begin
                            fault_q <= '0;
                            st_q    <= ST_RD0;
                        end
                    end
                end
                ST_RD0: begin
                    if (mem_ready) begin
                        w0_q <= mem_rdata;
                        st_q <= ST_RD1;
                    end
                end
                ST_RD1: begin
                    if (mem_ready) begin
                        if (c_match) begin
                            wb_q    <= c_wb;
                            rpn_q   <= mem_rdata[31:12];
                            hit_q   <= c_allowed;
                            pr_q    <= c_allowed & c_perm.r;
                            pw_q    <= c_allowed & c_perm.w;
                            fault_q <= c_allowed ? 32'h0 : (FLT_PROT | store_bit);
                            st_q    <= ST_WB;
                        end else if (idx_q == LAST_IDX) begin
                            if (!pass_q) begin
                                pass_q <= 1'b1;
                                idx_q  <= '0;
                                st_q   <= ST_RD0;
                            end else begin
                                fault_q <= FLT_NOPTE | store_bit;
                                st_q    <= ST_DONE;
                            end
                        end else begin
                            idx_q <= idx_q + 1'b1;
                            st_q  <= ST_RD0;
                        end
                    end
                end
                ST_WB: begin
                    if (mem_ready) st_q <= ST_DONE;
                end
                ST_DONE: st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign mem_req    = (st_q == ST_RD0) || (st_q == ST_RD1) || (st_q == ST_WB);
    assign mem_we     = (st_q == ST_WB);
    assign mem_addr   = (st_q == ST_RD0) ? ent_addr : (ent_addr | 32'h4);
    assign mem_wdata  = wb_q;
    assign busy       = (st_q != ST_IDLE);
    assign done       = (st_q == ST_DONE);
    assign hit        = hit_q;
    assign rpn        = rpn_q;
    assign perm_r     = pr_q;
    assign perm_w     = pw_q;
    assign fault_code = fault_q;

    logic unused_in;
    assign unused_in = ^{vaddr[11:0], sdr1[15:9], vaddr[27:12]};

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))) else $error("req dropped"); // R12
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done) else $error("done too long"); // R12
    AST_BUSY_AT_DONE: assert property (@(posedge clk) disable iff (rst)
        done |-> busy) else $error("busy low at done"); // R12
    AST_WB_REF_SET: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> mem_wdata[8]) else $error("ref bit missing"); // R10
    AST_HIT_NO_FAULT: assert property (@(posedge clk) disable iff (rst)
        (done && hit) |-> (fault_code == 32'h0)) else $error("hit with fault"); // R9
    AST_FAULT_STORE_FLAG: assert property (@(posedge clk) disable iff (rst)
        (done && !hit) |-> (fault_code[25] == write_q)) else $error("store flag"); // R9

endmodule

// File: tb/sim_hpt_walker.sv
module sim_hpt_walker;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic        start = 1'b0, is_write = 1'b0, is_fetch = 1'b0, user_mode = 1'b0;
    logic [31:0] vaddr = '0, sdr1 = '0;
    logic [511:0] seg_regs = '0;
    logic        mem_req, mem_we, mem_ready = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
    logic        busy, done, hit, perm_r, perm_w;
    logic [19:0] rpn;
    logic [31:0] fault_code;

    hpt_walker u0 (
        .clk(clk), .rst(rst), .start(start), .vaddr(vaddr), .is_write(is_write),
        .is_fetch(is_fetch), .user_mode(user_mode), .sdr1(sdr1), .seg_regs(seg_regs),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata), .busy(busy), .done(done),
        .hit(hit), .rpn(rpn), .perm_r(perm_r), .perm_w(perm_w), .fault_code(fault_code)
    );

    int checks = 0;
    int fails  = 0;
    logic [31:0] mem [logic [31:0]];
    int rd_cnt = 0, wb_cnt = 0;
    logic [31:0] first_rd, wb_addr, wb_data;

    // memory responder: one-cycle ready, driven away from the active edge
    always @(negedge clk) begin
        if (mem_ready) begin
            mem_ready <= 1'b0;
        end else if (mem_req) begin
            mem_ready <= 1'b1;
            if (mem_we) begin
                mem[mem_addr] = mem_wdata;
                wb_cnt  = wb_cnt + 1;
                wb_addr = mem_addr;
                wb_data = mem_wdata;
            end else begin
                if (rd_cnt == 0) first_rd = mem_addr;
                rd_cnt = rd_cnt + 1;
                mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] grp(logic [31:0] s, logic [23:0] vsid, logic [15:0] pg, logic h);
        logic [31:0] hs, m;
        hs = (({8'h0, vsid} ^ {16'h0, pg}) & 32'h0007FFFF) << 6;
        if (h) hs = ~hs & 32'h01FFFFC0;
        m = ({23'h0, s[8:0]} << 16) | 32'h0000FFC0;
        return (s & 32'hFFFF0000) | (hs & m);
    endfunction

    function automatic logic [31:0] pte0(logic [23:0] vsid, logic [15:0] pg, logic h);
        return {1'b1, vsid, h, pg[15:10]};
    endfunction

    task automatic put(input logic [31:0] a, input logic [31:0] w0, input logic [31:0] w1);
        mem[a] = w0;
        mem[a + 4] = w1;
    endtask

    task automatic set_seg(input int i, input logic [31:0] v);
        seg_regs[i*32 +: 32] = v;
    endtask

    task automatic run(input logic [31:0] va, input logic wr, input logic fe, input logic usr);
        @(negedge clk);
        vaddr = va; is_write = wr; is_fetch = fe; user_mode = usr;
        rd_cnt = 0; wb_cnt = 0; wb_addr = '0; wb_data = '0; first_rd = '0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R12 busy after start", {31'h0, busy}, 32'h1);
        for (int n = 0; n < 400 && !done; n++) @(negedge clk);
        check("R12 done seen", {31'h0, done}, 32'h1);
        @(negedge clk);
        check("R12 done one cycle", {30'h0, done, busy}, 32'h0);
    endtask

    localparam logic [31:0] SDR = 32'h00A0_0003;
    localparam logic [31:0] VA  = 32'h1234_5678;
    localparam logic [23:0] VS  = 24'h000123;
    localparam logic [15:0] PG  = 16'h2345;

    task automatic t_reset;
        check("R12 reset idle", {29'h0, busy, done, mem_req}, 32'h0);
        check("R9 reset fault", fault_code, 32'h0);
    endtask

    task automatic t_primary_read;
        logic [31:0] g;
        mem.delete();
        set_seg(1, {8'h00, VS});
        g = grp(SDR, VS, PG, 1'b0);
        put(g,      pte0(VS, PG, 1'b0) & 32'h7FFFFFFF, 32'h11111002);
        put(g + 8,  pte0(VS, PG, 1'b1), 32'h22222002);
        put(g + 16, pte0(VS, PG, 1'b0), 32'h0ABCD002);
        run(VA, 1'b0, 1'b0, 1'b0);
        check("R3 first read at group", first_rd, g);
        check("R4 skips invalid and wrong-H", {31'h0, hit}, 32'h1);
        check("R11 rpn", {12'h0, rpn}, 32'h0ABCD);
        check("R11 write perm cleared on read", {30'h0, perm_r, perm_w}, 32'h2);
        check("R10 wb addr", wb_addr, g + 20);
        check("R10 wb data ref only", wb_data, 32'h0ABCD102);
        check("R13 reads stop at match", rd_cnt, 6);
    endtask

    task automatic t_write_change;
        logic [31:0] g;
        mem.delete();
        g = grp(SDR, VS, PG, 1'b0);
        put(g + 16, pte0(VS, PG, 1'b0), 32'h0ABCD002);
        run(VA, 1'b1, 1'b0, 1'b0);
        check("R10 changed set on store", wb_data, 32'h0ABCD182);
        check("R7 key0 pp2 store ok", {29'h0, hit, perm_r, perm_w}, 32'h7);
        // C already set: read keeps write permission
        mem.delete();
        put(g, pte0(VS, PG, 1'b0), 32'h0ABCD082);
        run(VA, 1'b0, 1'b0, 1'b0);
        check("R11 C preset keeps write", {30'h0, perm_r, perm_w}, 32'h3);
    endtask

    task automatic t_key0_pp3;
        logic [31:0] g;
        mem.delete();
        g = grp(SDR, VS, PG, 1'b0);
        put(g, pte0(VS, PG, 1'b0), 32'h0ABCD003);
        run(VA, 1'b1, 1'b0, 1'b0);
        check("R7 key0 pp3 store denied", fault_code, 32'h0A000000);
        check("R9 hit low on denial", {31'h0, hit}, 32'h0);
        check("R10 ref still written", wb_data, 32'h0ABCD103);
        run(VA, 1'b0, 1'b0, 1'b0);
        check("R7 key0 pp3 read ok", {30'h0, hit, perm_r}, 32'h3);
    endtask

    task automatic t_key1;
        logic [31:0] g;
        mem.delete();
        set_seg(1, {8'h20, VS}); // bit29: user key
        g = grp(SDR, VS, PG, 1'b0);
        put(g, pte0(VS, PG, 1'b0), 32'h0ABCD000);
        run(VA, 1'b0, 1'b0, 1'b1);
        check("R8 key1 pp0 read denied", fault_code, 32'h08000000);
        run(VA, 1'b0, 1'b0, 1'b0);
        check("R1 supervisor with bit29 uses key0", {31'h0, hit}, 32'h1);
        put(g, pte0(VS, PG, 1'b0), 32'h0ABCD001);
        run(VA, 1'b0, 1'b0, 1'b1);
        check("R8 key1 pp1 read only", {29'h0, hit, perm_r, perm_w}, 32'h6);
        run(VA, 1'b1, 1'b0, 1'b1);
        check("R8 key1 pp1 store denied", fault_code, 32'h0A000000);
        put(g, pte0(VS, PG, 1'b0), 32'h0ABCD002);
        run(VA, 1'b1, 1'b0, 1'b1);
        check("R8 key1 pp2 store ok", {29'h0, hit, perm_r, perm_w}, 32'h7);
        set_seg(1, {8'h40, VS}); // bit30: supervisor key
        put(g, pte0(VS, PG, 1'b0), 32'h0ABCD000);
        run(VA, 1'b0, 1'b0, 1'b0);
        check("R1 supervisor bit30 key1", fault_code, 32'h08000000);
        run(VA, 1'b0, 1'b0, 1'b1);
        check("R1 user bit30 key0", {31'h0, hit}, 32'h1);
        set_seg(1, {8'h00, VS});
    endtask

    task automatic t_secondary;
        logic [31:0] g0, g1;
        mem.delete();
        g0 = grp(SDR, VS, PG, 1'b0);
        g1 = grp(SDR, VS, PG, 1'b1);
        put(g0 + 24, pte0(VS, PG, 1'b1), 32'h33333002);
        put(g1 + 32, pte0(VS, PG, 1'b1), 32'h0BEEF002);
        run(VA, 1'b0, 1'b0, 1'b0);
        check("R5 secondary hit", {31'h0, hit}, 32'h1);
        check("R5 secondary rpn", {12'h0, rpn}, 32'h0BEEF);
        check("R5 read count", rd_cnt, 26);
        check("R5 wb at secondary entry", wb_addr, g1 + 36);
    endtask

    task automatic t_miss;
        mem.delete();
        run(VA, 1'b1, 1'b0, 1'b0);
        check("R6 miss store fault", fault_code, 32'h42000000);
        check("R6 all entries read", rd_cnt, 32);
        check("R6 no write-back", wb_cnt, 0);
        run(VA, 1'b0, 1'b0, 1'b0);
        check("R6 miss read fault", fault_code, 32'h40000000);
    endtask

    task automatic t_dstore_noexec;
        mem.delete();
        set_seg(2, 32'h80000055);
        run(32'h2000_1000, 1'b0, 1'b0, 1'b0);
        check("R2 direct-store fault", fault_code, 32'h10000000);
        check("R2 no memory access", rd_cnt, 0);
        run(32'h2000_1000, 1'b1, 1'b0, 1'b0);
        check("R2 direct-store store", fault_code, 32'h12000000);
        set_seg(3, 32'h10000055);
        run(32'h3000_1000, 1'b0, 1'b1, 1'b0);
        check("R2 no-exec fetch", fault_code, 32'h10000000);
        check("R2 no access on fetch", rd_cnt, 0);
        run(32'h3000_1000, 1'b0, 1'b0, 1'b0);
        check("R2 data access walks", fault_code, 32'h40000000);
    endtask

    task automatic t_first_match;
        logic [31:0] g;
        mem.delete();
        g = grp(SDR, VS, PG, 1'b0);
        put(g + 24, pte0(VS, PG, 1'b0), 32'h0AAAA002);
        put(g + 40, pte0(VS, PG, 1'b0), 32'h0BBBB002);
        run(VA, 1'b0, 1'b0, 1'b0);
        check("R13 first match rpn", {12'h0, rpn}, 32'h0AAAA);
        check("R13 read count", rd_cnt, 8);
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        sdr1 = SDR;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_primary_read();
        t_write_change();
        t_key0_pp3();
        t_key1();
        t_secondary();
        t_miss();
        t_dstore_noexec();
        t_first_match();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule